// File: doc/BRIEF.md
# Debug Frame Realigner with Double-Rate Lane Output

This block sits beside a serial memory link and copies each southbound command frame onto a debug port for a logic analyzer. A frame arrives as three slots, A, B and C, which are presented together on one clock with a valid strobe. The low-latency ordering pairs the B and C slots of the previous frame with the A slot of the current frame. A host-order mode holds slot A back by one clock, so that the three slots of one host frame leave the block together and a capture shows the frame as the host sent it.

The realigned 168-bit frame word is cut into 14 lanes of 12 bits. Each lane leaves on 6 pins at double data rate: the low half is placed on the pins for capture on the rising clock edge and the high half for capture on the falling edge. Two differential clock pairs go with the lanes at the clock frequency, which is half the lane bit rate. A mode input picks the ordering. A change of mode is taken only together with a valid frame, and the output stays marked invalid until a full frame has been realigned under the new mode.

Top module: `dbgp_realign_top`

## Requirements
- R1: In host-order mode (host_order = 1), the frame presented before clock edge t appears, valid, on the lanes after edge t+1 as word {C, B, A}, with A in word bits 55:0, B in bits 111:56 and C in bits 167:112.
- R2: In low-latency mode (host_order = 0), when frames N-1 and N arrive on consecutive clocks, the word {C of N-1, B of N-1, A of N} appears, valid, after the edge that takes frame N. Without a frame on the previous clock, no valid word is produced.
- R3: Lane i carries word bits 12i+11 to 12i on pins 6i+5 to 6i. Bits 5:0 of the lane are on the pins while the clock is low, for capture on the rising edge. Bits 11:6 are on the pins while the clock is high, for capture on the falling edge. Both halves come from the same registered word.
- R4: dbg_clk_p[1:0] follows the clock on both pairs and dbg_clk_n[1:0] is its inverse.
- R5: After reset the active mode is low-latency. The mode input is taken only on a clock edge where frm_vld is high. A change on an idle clock has no effect on the ordering.
- R6: On the edge that takes a mode change, the frame that comes with the change is dropped and is not counted as a previous frame. lane_vld stays low after that edge and after the next one.
- R7: When no realigned frame is available, lane_vld is low and all lane pins drive zero.
- R8: While reset is asserted, lane_vld is low and all lane pins drive zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_order | input | 1 | 1 selects host-order (slot A delayed), 0 selects low-latency order |
| frm_vld | input | 1 | A frame is present on the slot inputs this clock |
| slot_a | input | 56 | Slot A of the current frame |
| slot_b | input | 56 | Slot B of the current frame |
| slot_c | input | 56 | Slot C of the current frame |
| lane_pins | output | 84 | 14 lanes of 6 double-rate pins |
| lane_vld | output | 1 | Lanes carry a realigned frame |
| dbg_clk_p | output | 2 | Forwarded debug clock, true side |
| dbg_clk_n | output | 2 | Forwarded debug clock, complement side |

## Verification
A mode switch and a frame arrival can happen on the same clock edge, because the mode is only taken with a valid frame. The bench arranges this in both directions: it raises host_order together with a frame while low-latency traffic is running, and it drops host_order together with a frame after host-order traffic. It then checks that the frame carried with the switch is dropped, that lane_vld stays low for two words, and that the next word follows the new ordering. A mode toggle on an idle clock, followed by traffic in the old mode, shows that the idle change was ignored.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  // Default geometry of the debug port.
  localparam int unsigned DEF_LANES     = 14;
  localparam int unsigned DEF_LANE_W    = 12;
  localparam int unsigned DEF_CLK_PAIRS = 2;
  localparam int unsigned NUM_SLOTS     = 3;

  // Slot positions inside the realigned word (A lowest).
  localparam int unsigned SLOT_A = 0;
  localparam int unsigned SLOT_B = 1;
  localparam int unsigned SLOT_C = 2;

  typedef enum logic {
    ORD_LOWLAT = 1'b0,
    ORD_HOST   = 1'b1
  } order_e;

endpackage

// File: rtl/dbgp_rst_sync.sv
module dbgp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/dbgp_slot_stage.sv
module dbgp_slot_stage
  import dbgp_pkg::*;
#(
  parameter int unsigned SLOT_W = 56
) (
  input  logic                               clk,
  input  logic                               rst_q,
  input  logic                               frm_vld,
  input  logic                               mode_req,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]   cur_slot,
  output order_e                             mode_act,
  output logic                               mode_sw,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]   st_slot,
  output logic                               st_vld
);

  order_e mode_nxt;
  logic   st_vld_nxt;
  logic   st_load;

  // Next-state: the mode moves only together with a frame.
  always_comb begin
    mode_sw    = frm_vld && (order_e'(mode_req) != mode_act);
    mode_nxt   = frm_vld ? order_e'(mode_req) : mode_act;
    st_vld_nxt = frm_vld && !mode_sw;
    st_load    = frm_vld;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mode_act <= ORD_LOWLAT;
      st_vld   <= 1'b0;
    end else begin
      mode_act <= mode_nxt;
      st_vld   <= st_vld_nxt;
    end
  end

  // One held copy per slot, loaded only when a frame arrives.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        st_slot[s] <= '0;
      end else if (st_load) begin
        st_slot[s] <= cur_slot[s];
      end
    end
  end

endmodule

// File: rtl/dbgp_realign.sv
module dbgp_realign
  import dbgp_pkg::*;
#(
  parameter int unsigned SLOT_W = 56
) (
  input  order_e                             mode_act,
  input  logic                               mode_sw,
  input  logic                               frm_vld,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]   cur_slot,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]   st_slot,
  input  logic                               st_vld,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]   word,
  output logic                               word_vld
);

  logic host_sel;

  assign host_sel = (mode_act == ORD_HOST);

  // Slot A picks its source by mode, B and C always come from the held frame.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    if (s == SLOT_A) begin : g_a
      always_comb begin
        word[s] = host_sel ? st_slot[s] : cur_slot[s];
      end
    end else begin : g_bc
      always_comb begin
        word[s] = st_slot[s];
      end
    end
  end

  always_comb begin
    if (host_sel) begin
      word_vld = st_vld;
    end else begin
      word_vld = st_vld && frm_vld;
    end
    if (mode_sw) begin
      word_vld = 1'b0;
    end
  end

endmodule

// File: rtl/dbgp_lane_out.sv
module dbgp_lane_out
  import dbgp_pkg::*;
#(
  parameter int unsigned LANES     = DEF_LANES,
  parameter int unsigned LANE_W    = DEF_LANE_W,
  parameter int unsigned CLK_PAIRS = DEF_CLK_PAIRS,
  localparam int unsigned HALF_W   = LANE_W / 2,
  localparam int unsigned WORD_W   = LANES * LANE_W,
  localparam int unsigned PIN_W    = LANES * HALF_W
) (
  input  logic                 clk,
  input  logic                 rst_q,
  input  logic [WORD_W-1:0]    word,
  input  logic                 word_vld,
  output logic [WORD_W-1:0]    lane_word,
  output logic                 lane_vld,
  output logic [PIN_W-1:0]     lane_pins,
  output logic [CLK_PAIRS-1:0] dbg_clk_p,
  output logic [CLK_PAIRS-1:0] dbg_clk_n
);

  logic lane_load;
  logic lane_vld_nxt;

  // Registers load a new word, or clear once when the stream stops.
  always_comb begin
    lane_load    = word_vld || lane_vld;
    lane_vld_nxt = word_vld;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lane_vld <= 1'b0;
    end else begin
      lane_vld <= lane_vld_nxt;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_nxt;
    logic [LANE_W-1:0] lane_q;

    always_comb begin
      lane_nxt = word_vld ? word[i*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        lane_q <= '0;
      end else if (lane_load) begin
        lane_q <= lane_nxt;
      end
    end

    assign lane_word[i*LANE_W +: LANE_W] = lane_q;

    // Low phase: low half for rising-edge capture. High phase: high half.
    assign lane_pins[i*HALF_W +: HALF_W] =
      clk ? lane_q[LANE_W-1:HALF_W] : lane_q[HALF_W-1:0];
  end

  for (genvar k = 0; k < CLK_PAIRS; k++) begin : g_clk
    assign dbg_clk_p[k] = clk;
    assign dbg_clk_n[k] = ~clk;
  end

endmodule

// File: rtl/dbgp_realign_top.sv
module dbgp_realign_top
  import dbgp_pkg::*;
#(
  parameter int unsigned LANES     = DEF_LANES,
  parameter int unsigned LANE_W    = DEF_LANE_W,
  parameter int unsigned CLK_PAIRS = DEF_CLK_PAIRS,
  parameter int unsigned RST_STG   = 2,
  localparam int unsigned FRAME_W  = LANES * LANE_W,
  localparam int unsigned SLOT_W   = FRAME_W / NUM_SLOTS,
  localparam int unsigned PIN_W    = LANES * (LANE_W / 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_order,
  input  logic                 frm_vld,
  input  logic [SLOT_W-1:0]    slot_a,
  input  logic [SLOT_W-1:0]    slot_b,
  input  logic [SLOT_W-1:0]    slot_c,
  output logic [PIN_W-1:0]     lane_pins,
  output logic                 lane_vld,
  output logic [CLK_PAIRS-1:0] dbg_clk_p,
  output logic [CLK_PAIRS-1:0] dbg_clk_n
);

  logic                             rst_q;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] cur_slot;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] st_slot;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] word;
  logic                             st_vld;
  logic                             mode_sw;
  logic                             word_vld;
  order_e                           mode_act;
  logic [FRAME_W-1:0]               lane_word;

  assign cur_slot[SLOT_A] = slot_a;
  assign cur_slot[SLOT_B] = slot_b;
  assign cur_slot[SLOT_C] = slot_c;

  dbgp_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  dbgp_slot_stage #(.SLOT_W(SLOT_W)) u_stage (
    .clk      (clk),
    .rst_q    (rst_q),
    .frm_vld  (frm_vld),
    .mode_req (host_order),
    .cur_slot (cur_slot),
    .mode_act (mode_act),
    .mode_sw  (mode_sw),
    .st_slot  (st_slot),
    .st_vld   (st_vld)
  );

  dbgp_realign #(.SLOT_W(SLOT_W)) u_align (
    .mode_act (mode_act),
    .mode_sw  (mode_sw),
    .frm_vld  (frm_vld),
    .cur_slot (cur_slot),
    .st_slot  (st_slot),
    .st_vld   (st_vld),
    .word     (word),
    .word_vld (word_vld)
  );

  dbgp_lane_out #(
    .LANES     (LANES),
    .LANE_W    (LANE_W),
    .CLK_PAIRS (CLK_PAIRS)
  ) u_out (
    .clk       (clk),
    .rst_q     (rst_q),
    .word      (word),
    .word_vld  (word_vld),
    .lane_word (lane_word),
    .lane_vld  (lane_vld),
    .lane_pins (lane_pins),
    .dbg_clk_p (dbg_clk_p),
    .dbg_clk_n (dbg_clk_n)
  );

endmodule

// File: rtl/dbgp_realign_chk.sv
module dbgp_realign_chk #(
  parameter int unsigned SLOT_W  = 56,
  parameter int unsigned FRAME_W = 168
) (
  input logic               clk,
  input logic               rst_q,
  input logic               frm_vld,
  input logic [SLOT_W-1:0]  slot_a,
  input logic [SLOT_W-1:0]  slot_b,
  input logic [SLOT_W-1:0]  slot_c,
  input logic               mode_act,
  input logic               lane_vld,
  input logic [FRAME_W-1:0] lane_word
);

  // R1: host order keeps one frame's slots together, two edges late.
  p_host_order_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (lane_vld && $past(mode_act)) |->
      (lane_word == {$past(slot_c, 2), $past(slot_b, 2), $past(slot_a, 2)}))
    else $error("p_host_order_r1");

  // R2: low-latency order joins B,C of the older frame with the newer A.
  p_norm_pair_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (lane_vld && !$past(mode_act)) |->
      (lane_word == {$past(slot_c, 2), $past(slot_b, 2), $past(slot_a, 1)}))
    else $error("p_norm_pair_r2");

  // R5: no frame, no mode movement.
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !frm_vld |=> $stable(mode_act))
    else $error("p_mode_hold_r5");

  // R6: the word leaving with a switch is blanked.
  p_switch_blank_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_act != $past(mode_act)) |-> !lane_vld)
    else $error("p_switch_blank_r6");

  // R6: and so is the following one.
  p_switch_next_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_act != $past(mode_act)) |=> !lane_vld)
    else $error("p_switch_next_r6");

  // R7: invalid lanes are zero.
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !lane_vld |-> (lane_word == '0))
    else $error("p_idle_zero_r7");

endmodule

bind dbgp_realign_top dbgp_realign_chk #(
  .SLOT_W  (SLOT_W),
  .FRAME_W (FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .frm_vld   (frm_vld),
  .slot_a    (slot_a),
  .slot_b    (slot_b),
  .slot_c    (slot_c),
  .mode_act  (mode_act),
  .lane_vld  (lane_vld),
  .lane_word (lane_word)
);

// File: tb/tb_dbgp_realign_top.sv
module tb_dbgp_realign_top;

  localparam int SW = 56;
  localparam int WW = 168;
  localparam int PW = 84;

  logic          clk;
  logic          rst_n;
  logic          host_order;
  logic          frm_vld;
  logic [SW-1:0] slot_a, slot_b, slot_c;
  logic [PW-1:0] lane_pins;
  logic          lane_vld;
  logic [1:0]    dbg_clk_p, dbg_clk_n;

  int            n_chk;
  int            n_err;
  bit            done;
  logic [WW-1:0] got;
  logic          gv;
  logic [PW-1:0] pins_hi, pins_lo;

  dbgp_realign_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_order (host_order),
    .frm_vld    (frm_vld),
    .slot_a     (slot_a),
    .slot_b     (slot_b),
    .slot_c     (slot_c),
    .lane_pins  (lane_pins),
    .lane_vld   (lane_vld),
    .dbg_clk_p  (dbg_clk_p),
    .dbg_clk_n  (dbg_clk_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [SW-1:0] mk(input int n, input int s);
    return {8'(n), 8'(s), 40'hC3A596F00F ^ 40'(n * 1234567)};
  endfunction

  function automatic logic [WW-1:0] fw(input int n);
    return {mk(n, 3), mk(n, 2), mk(n, 1)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Read both phases of the current registered word (ends in low phase).
  task automatic read_out();
    @(posedge clk);
    #5;
    pins_hi = lane_pins;
    gv      = lane_vld;
    @(negedge clk);
    #5;
    pins_lo = lane_pins;
    for (int i = 0; i < 14; i++) begin
      got[i*12 +: 6]     = pins_lo[i*6 +: 6];
      got[i*12 + 6 +: 6] = pins_hi[i*6 +: 6];
    end
  endtask

  task automatic step(input logic v, input logic m, input int n);
    frm_vld    = v;
    host_order = m;
    slot_a     = v ? mk(n, 1) : '0;
    slot_b     = v ? mk(n, 2) : '0;
    slot_c     = v ? mk(n, 3) : '0;
    read_out();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frm_vld = 1'b0; host_order = 1'b0;
    slot_a = mk(99, 1); slot_b = mk(99, 2); slot_c = mk(99, 3);
    read_out();
    chk("R8", "valid in reset", WW'(gv), '0);
    chk("R8", "pins in reset", got, '0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0);
    chk("R7", "idle after reset", got, '0);
  endtask

  task automatic t_lowlat();
    step(1'b1, 1'b0, 1);
    chk("R2", "no previous frame", WW'(gv), '0);
    step(1'b1, 1'b0, 2);
    chk("R2", "valid F2", WW'(gv), WW'(1));
    chk("R2", "word F1/F2", got, {mk(1, 3), mk(1, 2), mk(2, 1)});
    step(1'b1, 1'b0, 3);
    chk("R2", "word F2/F3", got, {mk(2, 3), mk(2, 2), mk(3, 1)});
    step(1'b0, 1'b0, 0);
    chk("R7", "idle valid", WW'(gv), '0);
    chk("R7", "idle pins", got, '0);
  endtask

  task automatic t_idle_mode();
    step(1'b0, 1'b1, 0);
    chk("R7", "idle with mode toggle", got, '0);
    step(1'b1, 1'b0, 4);
    chk("R5", "first after idle", WW'(gv), '0);
    step(1'b1, 1'b0, 5);
    chk("R5", "idle toggle ignored valid", WW'(gv), WW'(1));
    chk("R5", "idle toggle ignored word", got, {mk(4, 3), mk(4, 2), mk(5, 1)});
  endtask

  task automatic t_to_host();
    step(1'b1, 1'b1, 6);
    chk("R6", "switch edge blank", {WW'(gv) | got}, '0);
    step(1'b1, 1'b1, 7);
    chk("R6", "after switch blank", {WW'(gv) | got}, '0);
    step(1'b1, 1'b1, 8);
    chk("R1", "host valid", WW'(gv), WW'(1));
    chk("R1", "host word F7", got, fw(7));
    step(1'b1, 1'b1, 9);
    chk("R1", "host word F8", got, fw(8));
    step(1'b0, 1'b1, 0);
    chk("R1", "host tail F9", got, fw(9));
    chk("R3", "lane0 rise half", WW'(pins_lo[5:0]), WW'(fw(9)[5:0]));
    chk("R3", "lane0 fall half", WW'(pins_hi[5:0]), WW'(fw(9)[11:6]));
    chk("R3", "lane13 rise half", WW'(pins_lo[83:78]), WW'(fw(9)[161:156]));
    chk("R3", "lane13 fall half", WW'(pins_hi[83:78]), WW'(fw(9)[167:162]));
    step(1'b0, 1'b1, 0);
    chk("R7", "host idle zero", {WW'(gv) | got}, '0);
  endtask

  task automatic t_to_lowlat();
    step(1'b1, 1'b0, 10);
    chk("R6", "switch back blank", {WW'(gv) | got}, '0);
    step(1'b1, 1'b0, 11);
    chk("R6", "switch frame dropped", {WW'(gv) | got}, '0);
    step(1'b1, 1'b0, 12);
    chk("R2", "word F11/F12", got, {mk(11, 3), mk(11, 2), mk(12, 1)});
  endtask

  task automatic t_clock();
    frm_vld = 1'b0;
    @(posedge clk);
    #5;
    chk("R4", "clk p high", WW'(dbg_clk_p), WW'(2'b11));
    chk("R4", "clk n high", WW'(dbg_clk_n), WW'(2'b00));
    @(negedge clk);
    #5;
    chk("R4", "clk p low", WW'(dbg_clk_p), WW'(2'b00));
    chk("R4", "clk n low", WW'(dbg_clk_n), WW'(2'b11));
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    t_reset();
    t_lowlat();
    t_idle_mode();
    t_to_host();
    t_to_lowlat();
    t_clock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule